// File: doc/BRIEF.md
# Majority-Vote Predictor State Codec

This block shrinks and regrows the counter state of a correlating branch predictor so that it can be parked in a small store while another program runs. The packing path accepts one 128-bit word of 2-bit saturating counters per beat. It splits the counters into groups of `GROUP` neighbours and replaces each group with one bit: the majority of the counters' predicted directions. The unpacking path takes such vote bits and rebuilds full counter words. Every counter in a group comes back in the weak state of the voted direction.

Both paths are pipelined and fully independent. Each has its own valid/ready handshake on input and on output, so a save stream and a restore stream can be in flight at the same time. `GROUP` is fixed at elaboration to 4 (4:1 ratio, 16 vote bits per word) or 8 (8:1 ratio, 8 vote bits per word).

The loss is intended. When a group is split evenly, at worst half of its restored counters disagree with their original direction. A predictor tolerates this because it only guesses. The block holds no table and does no context-switch sequencing. A surrounding controller streams the words through it.

Top module: `pred_vote_codec`

## Requirements
- R1: `GROUP` must be 4 or 8. The vote word width is 128/2/`GROUP` bits: 16 for 4 and 8 for 8.
- R2: Counter i occupies data bits [2i+1:2i], and its direction is bit 2i+1 (1 = taken). Vote bit g is the majority direction of counters g·`GROUP` through g·`GROUP`+`GROUP`−1, so groups are packed in ascending order from bit 0.
- R3: A group with exactly `GROUP`/2 taken counters votes taken (1).
- R4: The strength bit (bit 2i) has no effect on the vote. A weak and a strong counter of the same direction give the same result.
- R5: On unpacking, counter i of the output word is 2'b10 when vote bit floor(i/`GROUP`) is 1, and 2'b01 when it is 0.
- R6: Without backpressure, a packed result is valid two clock edges after its input is accepted, and an unpacked result one edge after. Each path accepts one beat per cycle.
- R7: While an output is valid and not ready, that output keeps its valid and its data unchanged. No beat is lost, duplicated or reordered.
- R8: Stalling one path does not affect the acceptance or output of the other path.
- R9: During and right after reset, neither output is valid and both inputs are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| packInValid | input | 1 | Counter word offered for packing |
| packInReady | output | 1 | Packing path can take a word |
| packInData | input | 128 | 64 two-bit counters |
| packOutValid | output | 1 | Vote word available |
| packOutReady | input | 1 | Consumer takes the vote word |
| packOutBits | output | 128/2/GROUP | Vote bits, group 0 in bit 0 |
| unpackInValid | input | 1 | Vote word offered for unpacking |
| unpackInReady | output | 1 | Unpacking path can take a vote word |
| unpackInBits | input | 128/2/GROUP | Vote bits, group 0 in bit 0 |
| unpackOutValid | output | 1 | Rebuilt counter word available |
| unpackOutReady | input | 1 | Consumer takes the counter word |
| unpackOutData | output | 128 | 64 rebuilt weak counters |

## Verification
On every cycle, the bound checker watches four things. It checks that a stalled output of either path holds its valid and data. It checks that the unpacked word contains only weak counters that agree within each group. It checks the latency from accept to valid on both paths. It checks that each input is ready whenever its output is not blocked. The vote rule itself needs the bench's scenarios: the tie resolving to taken, strength having no effect, and group ordering. So do the exact bit values of the vote and rebuilt words, freedom from loss or duplication over long streams with random backpressure, and isolation of one path while the other is stalled.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] WEAK_TAKEN     = 2'b10;
  localparam logic [CNT_W-1:0] WEAK_NOT_TAKEN = 2'b01;

  // Strobes from a flow controller to its datapath.
  typedef struct packed {
    logic advance;   // all occupied stages move forward
    logic capture;   // first stage loads a new input beat
  } pvc_strobe_t;
endpackage

// File: rtl/pvc_flow_ctrl.sv
module pvc_flow_ctrl
  import pvc_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output pvc_strobe_t strobe
);
  logic [DEPTH-1:0] stageValid;
  logic             moveOn;

  // The whole pipe moves unless the last stage holds a beat nobody takes.
  assign moveOn         = !stageValid[DEPTH-1] || outReady;
  assign inReady        = moveOn;
  assign outValid       = stageValid[DEPTH-1];
  assign strobe.advance = moveOn;
  assign strobe.capture = moveOn && inValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= '0;
    end else if (moveOn) begin
      stageValid[0] <= inValid;
      for (int d = 1; d < DEPTH; d++) begin
        stageValid[d] <= stageValid[d-1];
      end
    end
  end
endmodule

// File: rtl/pvc_vote_datapath.sv
module pvc_vote_datapath
  import pvc_pkg::*;
#(
  parameter int WORD_W = 128,
  parameter int GROUP  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pvc_strobe_t                strobe,
  input  logic [WORD_W-1:0]          inData,
  output logic [WORD_W/CNT_W/GROUP-1:0] votes
);
  localparam int CNT_N  = WORD_W / CNT_W;
  localparam int VOTES  = CNT_N / GROUP;
  localparam int SUM_W  = $clog2(GROUP) + 1;
  localparam int HALF   = GROUP / 2;

  logic [SUM_W-1:0] sumNext [VOTES];
  logic [SUM_W-1:0] sumQ    [VOTES];
  logic [VOTES-1:0] voteQ;

  for (genvar g = 0; g < VOTES; g++) begin : g_group
    // Stage 1: population count of the direction bits in this group.
    always_comb begin
      sumNext[g] = '0;
      for (int k = 0; k < GROUP; k++) begin
        sumNext[g] = sumNext[g] + SUM_W'(inData[CNT_W*(g*GROUP+k)+1]);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sumQ[g] <= '0;
      end else if (strobe.capture) begin
        sumQ[g] <= sumNext[g];
      end
    end

    // Stage 2: compare against half the group; a tie counts as taken.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        voteQ[g] <= 1'b0;
      end else if (strobe.advance) begin
        voteQ[g] <= (sumQ[g] >= SUM_W'(HALF));
      end
    end
  end

  assign votes = voteQ;
endmodule

// File: rtl/pvc_fill_datapath.sv
module pvc_fill_datapath
  import pvc_pkg::*;
#(
  parameter int WORD_W = 128,
  parameter int GROUP  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pvc_strobe_t                   strobe,
  input  logic [WORD_W/CNT_W/GROUP-1:0] votes,
  output logic [WORD_W-1:0]             outData
);
  localparam int CNT_N = WORD_W / CNT_W;

  logic [WORD_W-1:0] fillQ;

  for (genvar i = 0; i < CNT_N; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fillQ[CNT_W*i +: CNT_W] <= WEAK_NOT_TAKEN;
      end else if (strobe.capture) begin
        fillQ[CNT_W*i +: CNT_W] <= votes[i/GROUP] ? WEAK_TAKEN : WEAK_NOT_TAKEN;
      end
    end
  end

  assign outData = fillQ;
endmodule

// File: rtl/pred_vote_codec.sv
module pred_vote_codec
  import pvc_pkg::*;
#(
  parameter int WORD_W = 128,
  parameter int GROUP  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          packInValid,
  output logic                          packInReady,
  input  logic [WORD_W-1:0]             packInData,
  output logic                          packOutValid,
  input  logic                          packOutReady,
  output logic [WORD_W/CNT_W/GROUP-1:0] packOutBits,
  input  logic                          unpackInValid,
  output logic                          unpackInReady,
  input  logic [WORD_W/CNT_W/GROUP-1:0] unpackInBits,
  output logic                          unpackOutValid,
  input  logic                          unpackOutReady,
  output logic [WORD_W-1:0]             unpackOutData
);
  // R1: only the two supported ratios elaborate.
  if (GROUP != 4 && GROUP != 8) begin : g_bad_group
    $error("GROUP must be 4 or 8");
  end

  pvc_strobe_t packStrobe;
  pvc_strobe_t unpackStrobe;

  pvc_flow_ctrl #(.DEPTH(2)) u_pack_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(packInValid), .inReady(packInReady),
    .outValid(packOutValid), .outReady(packOutReady),
    .strobe(packStrobe)
  );

  pvc_vote_datapath #(.WORD_W(WORD_W), .GROUP(GROUP)) u_vote (
    .clk(clk), .rstN(rstN), .strobe(packStrobe),
    .inData(packInData), .votes(packOutBits)
  );

  pvc_flow_ctrl #(.DEPTH(1)) u_unpack_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(unpackInValid), .inReady(unpackInReady),
    .outValid(unpackOutValid), .outReady(unpackOutReady),
    .strobe(unpackStrobe)
  );

  pvc_fill_datapath #(.WORD_W(WORD_W), .GROUP(GROUP)) u_fill (
    .clk(clk), .rstN(rstN), .strobe(unpackStrobe),
    .votes(unpackInBits), .outData(unpackOutData)
  );
endmodule

// File: rtl/pvc_checker.sv
module pvc_checker #(
  parameter int WORD_W = 128,
  parameter int GROUP  = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        packInValid,
  input logic                        packInReady,
  input logic                        packOutValid,
  input logic                        packOutReady,
  input logic [WORD_W/2/GROUP-1:0]   packOutBits,
  input logic                        unpackInValid,
  input logic                        unpackInReady,
  input logic                        unpackOutValid,
  input logic                        unpackOutReady,
  input logic [WORD_W-1:0]           unpackOutData
);
  localparam int CNT_N = WORD_W / 2;

  function automatic logic wellFormed(input logic [WORD_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < CNT_N; i++) begin
      if (w[2*i +: 2] != 2'b10 && w[2*i +: 2] != 2'b01) ok = 1'b0;
      if (w[2*i +: 2] != w[2*((i/GROUP)*GROUP) +: 2]) ok = 1'b0;
    end
    return ok;
  endfunction

  assert_pack_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    packOutValid && !packOutReady |=> packOutValid && $stable(packOutBits));

  assert_unpack_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    unpackOutValid && !unpackOutReady |=> unpackOutValid && $stable(unpackOutData));

  assert_fill_weak_R5: assert property (@(posedge clk) disable iff (!rstN)
    unpackOutValid |-> wellFormed(unpackOutData));

  assert_pack_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    packInValid && packInReady |-> ##2 packOutValid);

  assert_unpack_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    unpackInValid && unpackInReady |=> unpackOutValid);

  assert_pack_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(packOutValid && !packOutReady) |-> packInReady);

  assert_unpack_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(unpackOutValid && !unpackOutReady) |-> unpackInReady);
endmodule

bind pred_vote_codec pvc_checker #(.WORD_W(WORD_W), .GROUP(GROUP)) u_pvc_checker (
  .clk(clk), .rstN(rstN),
  .packInValid(packInValid), .packInReady(packInReady),
  .packOutValid(packOutValid), .packOutReady(packOutReady),
  .packOutBits(packOutBits),
  .unpackInValid(unpackInValid), .unpackInReady(unpackInReady),
  .unpackOutValid(unpackOutValid), .unpackOutReady(unpackOutReady),
  .unpackOutData(unpackOutData)
);

// File: tb/pred_vote_codec_bench.sv
module pred_vote_codec_bench;
  localparam int WORD_W = 128;
  localparam int GROUP  = 4;
  localparam int CNT_N  = WORD_W / 2;
  localparam int VOTES  = CNT_N / GROUP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic packInValid = 1'b0, packInReady, packOutValid, packOutReady = 1'b1;
  logic [WORD_W-1:0] packInData = '0;
  logic [VOTES-1:0]  packOutBits;
  logic unpackInValid = 1'b0, unpackInReady, unpackOutValid, unpackOutReady = 1'b1;
  logic [VOTES-1:0]  unpackInBits = '0;
  logic [WORD_W-1:0] unpackOutData;

  always #4 clk = ~clk;  // 125 MHz

  pred_vote_codec #(.WORD_W(WORD_W), .GROUP(GROUP)) u_pred_vote_codec (.*);

  int checks = 0;
  int fails  = 0;
  int unpackSeen = 0;
  string curReq = "R2";
  bit randReady = 1'b0;

  logic [VOTES-1:0]  packQ[$];
  logic [WORD_W-1:0] unpackQ[$];

  task automatic check(input bit ok, input string req,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected models written from the requirements.
  function automatic logic [VOTES-1:0] voteOf(input logic [WORD_W-1:0] w);
    logic [VOTES-1:0] v;
    for (int g = 0; g < VOTES; g++) begin
      int n;
      n = 0;
      for (int k = 0; k < GROUP; k++) n += int'(w[2*(g*GROUP+k)+1]);
      v[g] = (n * 2 >= GROUP);
    end
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] fillOf(input logic [VOTES-1:0] v);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < CNT_N; i++) w[2*i +: 2] = v[i/GROUP] ? 2'b10 : 2'b01;
    return w;
  endfunction

  task automatic sendPack(input logic [WORD_W-1:0] d);
    bit fired;
    packInValid = 1'b1;
    packInData  = d;
    do begin
      @(negedge clk); fired = packInReady;
      @(posedge clk); #1;
    end while (!fired);
    packQ.push_back(voteOf(d));
    packInValid = 1'b0;
  endtask

  task automatic sendUnpack(input logic [VOTES-1:0] v);
    bit fired;
    unpackInValid = 1'b1;
    unpackInBits  = v;
    do begin
      @(negedge clk); fired = unpackInReady;
      @(posedge clk); #1;
    end while (!fired);
    unpackQ.push_back(fillOf(v));
    unpackInValid = 1'b0;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rstN && packOutValid && packOutReady) begin
      if (packQ.size() == 0) check(1'b0, {curReq, "/R7 extra pack beat"}, WORD_W'(packOutBits), '0);
      else begin
        logic [VOTES-1:0] e;
        e = packQ.pop_front();
        check(packOutBits == e, {curReq, " pack vote"}, WORD_W'(packOutBits), WORD_W'(e));
      end
    end
    if (rstN && unpackOutValid && unpackOutReady) begin
      unpackSeen++;
      if (unpackQ.size() == 0) check(1'b0, {curReq, "/R7 extra unpack beat"}, unpackOutData, '0);
      else begin
        logic [WORD_W-1:0] e;
        e = unpackQ.pop_front();
        check(unpackOutData == e, {curReq, " unpack fill"}, unpackOutData, e);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (randReady) begin
      packOutReady   = ($urandom % 4) != 0;
      unpackOutReady = ($urandom % 3) != 0;
    end
  end

  task automatic drain();
    for (int t = 0; t < 200 && (packQ.size() != 0 || unpackQ.size() != 0); t++) @(posedge clk);
    #1;
    check(packQ.size() == 0 && unpackQ.size() == 0, "R7 all beats delivered",
          WORD_W'(packQ.size()), WORD_W'(unpackQ.size()));
  endtask

  task automatic runAll();
    logic [VOTES-1:0] held;
    int seenBefore;
    void'($urandom(7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!packOutValid && !unpackOutValid, "R9 outputs idle in reset",
          {packOutValid, unpackOutValid}, '0);
    check(packInReady && unpackInReady, "R9 inputs ready in reset",
          {packInReady, unpackInReady}, 2'b11);
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    check(!packOutValid && !unpackOutValid && packInReady && unpackInReady,
          "R9 state after reset", {packOutValid, unpackOutValid, packInReady, unpackInReady}, 4'b0011);

    // R1: vote word width for GROUP=4.
    check($bits(packOutBits) == 16, "R1 vote width", $bits(packOutBits), 16);

    // R6: latency with open outputs.
    @(posedge clk); #1;
    sendPack({64{2'b11}});
    @(negedge clk);
    check(!packOutValid, "R6 pack not valid after one edge", packOutValid, 0);
    @(negedge clk);
    check(packOutValid && packOutBits == '1, "R6 pack valid after two edges",
          {packOutValid, packOutBits}, {1'b1, 16'hFFFF});
    @(posedge clk); #1;
    sendUnpack(16'hA5C3);
    @(negedge clk);
    check(unpackOutValid, "R6 unpack valid after one edge", unpackOutValid, 1);
    drain();

    // R2: group order and plain majorities.
    curReq = "R2";
    sendPack({64{2'b00}});
    sendPack({16{8'b0010_1011}});               // 3 of 4 taken -> 1
    sendPack({16{8'b1100_0000}});               // 1 of 4 taken -> 0
    sendPack({{15{8'h00}}, 8'hFF, 112'h0});     // only group 1 taken... group index 14
    sendPack({120'h0, 8'hAA});                  // only group 0 taken
    // R3: ties resolve to taken.
    curReq = "R3";
    sendPack({16{8'b1111_0000}});
    sendPack({16{8'b1000_1000}});
    // R4: strength bit ignored.
    curReq = "R4";
    sendPack({64{2'b10}});
    sendPack({64{2'b01}});
    sendPack({16{8'b0101_1010}});
    // R5: fill patterns.
    curReq = "R5";
    sendUnpack('0);
    sendUnpack('1);
    sendUnpack(16'h0001);
    sendUnpack(16'h8000);
    drain();

    // R7 + R8: stall the pack output while the unpack path streams.
    curReq = "R7";
    packOutReady = 1'b0;
    sendPack({64{2'b11}});
    sendPack({64{2'b00}});
    @(negedge clk);
    held = packOutBits;
    check(packOutValid && !packInReady, "R7 stalled pipe full and blocking",
          {packOutValid, packInReady}, 2'b10);
    curReq = "R8";
    seenBefore = unpackSeen;
    @(posedge clk); #1;
    for (int j = 0; j < 4; j++) sendUnpack(VOTES'(16'h1111 << j));
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(unpackSeen == seenBefore + 4, "R8 unpack flows while pack stalled",
          unpackSeen - seenBefore, 4);
    check(packOutValid && packOutBits == held, "R7 stalled output held",
          WORD_W'(packOutBits), WORD_W'(held));
    @(posedge clk); #1;
    packOutReady = 1'b1;
    drain();

    // Random stress on both paths with random backpressure.
    curReq = "R7";
    randReady = 1'b1;
    fork
      for (int j = 0; j < 300; j++) sendPack({$urandom, $urandom, $urandom, $urandom});
      for (int j = 0; j < 300; j++) sendUnpack(VOTES'($urandom));
    join
    randReady = 1'b0;
    @(posedge clk); #1;
    packOutReady = 1'b1;
    unpackOutReady = 1'b1;
    drain();
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule